// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block holds the programmable state of an interrupt redirection controller with a parameterised number of input pins (24 by default). Software never addresses the storage directly: it first writes a slot number into a select register, then reads or writes a single 32-bit data window. The slot number picks an identification register, a fixed version word, an arbitration word that is always zero, or one half of a 64-bit redirection entry per input pin.

The entries are presented in parallel on a flat output bus to the delivery logic, which lives elsewhere. Whenever software writes the window while it points at an existing entry, the block raises a one-cycle rescan request so that the delivery logic re-evaluates pending pins. Writes to the low half of an entry pass through a legality filter: an unmasked entry whose vector is outside the permitted range is not stored, although the rescan request still fires.

A small access sequencer with three states runs the block. ACC_IDLE is the resting state; ACC_READ is the cycle in which freshly captured read data is presented; ACC_SCAN is the cycle in which the rescan request is driven. From every state the next state is chosen by the current strobe: a window write aimed at an entry goes to ACC_SCAN, any read goes to ACC_READ, anything else returns to ACC_IDLE.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select register is 0x00, the identification value equals parameter ID_RESET (default 0x00), every entry holds 0x0000_0000_0001_0000 (bit 16 set, so masked), rescan is low and bus_rdata is zero.
- R2: A write to offset 0x00 stores bus_wdata[7:0] into the select register; a read of offset 0x00 returns the select value in bits 7:0 with bits 31:8 zero.
- R3: Only offsets 0x00 and 0x10 are decoded; a read of any other offset returns zero and a write to any other offset changes nothing.
- R4: With select 0x00 the window reads the identification value in bits 31:24 and zero elsewhere; a window write stores bus_wdata[31:24] as the new identification value.
- R5: With select 0x01 the window reads {8'h00, NUM_PINS-1, 8'h00, 8'h11} (0x00170011 for 24 pins); window writes there have no effect.
- R6: With select 0x02, and with any select from 0x03 to 0x0F, the window reads zero and writes have no effect.
- R7: A select s of 0x10 or more addresses entry n = (s - 0x10) / 2; an even s reaches entry bits 31:0 and an odd s bits 63:32. Entry n appears on entries_flat[64n+63:64n], and entries change only on a window write.
- R8: A select whose entry number is NUM_PINS or more reads zero, and a window write to it changes nothing and raises no rescan.
- R9: A window write to a low half is stored only if bus_wdata[16] (mask) is set or bus_wdata[7:0] lies in 0x10..0xFE; otherwise the entry keeps its old value.
- R10: A window write to a high half is always stored in full.
- R11: rescan is high for exactly the cycle after each window write that addresses an existing entry, whether or not the filter of R9 accepted it; it is low in every other cycle.
- R12: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read; reads and writes are never strobed together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rescan | output | 1 | One-cycle request to re-evaluate pending pins |
| entries_flat | output | NUM_PINS*64 | All redirection entries, entry n at bits 64n+63:64n |

## Verification
The two functions that meet in one cycle are the rescan pulse from a table write and a read of the same entry issued immediately after it. The bench writes an entry and strobes a window read in the very next cycle, while rescan is high, and judges that the pulse is one cycle wide and that the read returns the value just stored (or the old value when the filter dropped the write). Back-to-back entry writes are also issued so that rescan must stay high for two consecutive cycles, each attributable to its own write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Bus offsets within the window
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;

    // Select values
    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_TBL_BASE = 8'h10;

    // Fixed identification constants
    localparam logic [7:0] VERSION_CODE = 8'h11;
    localparam int         MASK_BIT     = 16;
    localparam logic [7:0] VEC_MIN      = 8'h10;
    localparam logic [7:0] VEC_MAX      = 8'hFE;
    localparam int         ENT_W        = 64;
    localparam logic [ENT_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_SCAN
    } acc_state_t;

    typedef enum logic [2:0] {
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENTRY_LO,
        TGT_ENTRY_HI,
        TGT_NONE
    } tgt_t;

endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic [7:0]       sel,
    output tgt_t             tgt,
    output logic [IDX_W-1:0] idx
);

    logic [7:0] rel;
    logic [6:0] slot;

    always_comb begin
        rel  = sel - SEL_TBL_BASE;
        slot = rel[7:1];
        idx  = slot[IDX_W-1:0];
        tgt  = TGT_NONE;
        if (sel == SEL_ID) begin
            tgt = TGT_ID;
        end else if (sel == SEL_VER) begin
            tgt = TGT_VER;
        end else if (sel == SEL_ARB) begin
            tgt = TGT_ARB;
        end else if ((sel >= SEL_TBL_BASE) && (int'(slot) < NUM_PINS)) begin
            tgt = rel[0] ? TGT_ENTRY_HI : TGT_ENTRY_LO;
        end
    end

endmodule

// File: rtl/irq_entry_filter.sv
module irq_entry_filter
    import irq_route_pkg::*;
(
    input  logic [31:0] wdata,
    output logic        accept
);

    logic masked;
    logic vec_ok;

    always_comb begin
        masked = wdata[MASK_BIT];
        vec_ok = (wdata[7:0] >= VEC_MIN) && (wdata[7:0] <= VEC_MAX);
        accept = masked || vec_ok;
    end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IDX_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [IDX_W-1:0]          idx,
    input  logic [31:0]               wdata,
    output logic [31:0]               rd_lo,
    output logic [31:0]               rd_hi,
    output logic [NUM_PINS*ENT_W-1:0] entries_flat
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
        logic [ENT_W-1:0] ent_q;
        logic             hit;

        assign hit = (idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= ENTRY_RESET;
            end else begin
                if (wr_lo && hit) ent_q[31:0]  <= wdata;
                if (wr_hi && hit) ent_q[63:32] <= wdata;
            end
        end

        assign entries_flat[g*ENT_W +: ENT_W] = ent_q;
    end

    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_lo = entries_flat[i*ENT_W +: 32];
                rd_hi = entries_flat[i*ENT_W + 32 +: 32];
            end
        end
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] ID_RESET = 8'h00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [7:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      rescan,
    output logic [NUM_PINS*64-1:0]    entries_flat
);

    localparam int         IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [7:0] MAX_IDX8 = 8'(NUM_PINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, MAX_IDX8, 8'h00, VERSION_CODE};

    acc_state_t       state_q, state_d;
    logic [7:0]       sel_q;
    logic [7:0]       id_q;
    logic [31:0]      rdata_q;
    logic [31:0]      rd_mux;

    tgt_t             tgt;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic [31:0]      rd_lo, rd_hi;

    logic sel_wr, win_wr, entry_hit, wr_lo, wr_hi;

    irq_sel_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
        .sel (sel_q),
        .tgt (tgt),
        .idx (idx)
    );

    irq_entry_filter u_flt (
        .wdata  (bus_wdata),
        .accept (accept)
    );

    always_comb begin
        sel_wr    = bus_wr && (bus_addr == OFS_SEL);
        win_wr    = bus_wr && (bus_addr == OFS_WIN);
        entry_hit = win_wr && ((tgt == TGT_ENTRY_LO) || (tgt == TGT_ENTRY_HI));
        wr_lo     = win_wr && (tgt == TGT_ENTRY_LO) && accept;
        wr_hi     = win_wr && (tgt == TGT_ENTRY_HI);
    end

    irq_redir_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_lo        (wr_lo),
        .wr_hi        (wr_hi),
        .idx          (idx),
        .wdata        (bus_wdata),
        .rd_lo        (rd_lo),
        .rd_hi        (rd_hi),
        .entries_flat (entries_flat)
    );

    // Select and identification registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 8'h00;
            id_q  <= ID_RESET;
        end else begin
            if (sel_wr) sel_q <= bus_wdata[7:0];
            if (win_wr && (tgt == TGT_ID)) id_q <= bus_wdata[31:24];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        if (bus_addr == OFS_SEL) begin
            rd_mux = {24'h0, sel_q};
        end else if (bus_addr == OFS_WIN) begin
            unique case (tgt)
                TGT_ID:       rd_mux = {id_q, 24'h0};
                TGT_VER:      rd_mux = VER_WORD;
                TGT_ARB:      rd_mux = '0;
                TGT_ENTRY_LO: rd_mux = rd_lo;
                TGT_ENTRY_HI: rd_mux = rd_hi;
                default:      rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    // Access sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // Access sequencer: transitions
    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_READ, ACC_SCAN: begin
                if (entry_hit)   state_d = ACC_SCAN;
                else if (bus_rd) state_d = ACC_READ;
                else             state_d = ACC_IDLE;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    // Access sequencer: outputs
    always_comb begin
        rescan = 1'b0;
        unique case (state_q)
            ACC_IDLE: rescan = 1'b0;
            ACC_READ: rescan = 1'b0;
            ACC_SCAN: rescan = 1'b1;
            default:  rescan = 1'b0;
        endcase
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
    parameter int NUM_PINS = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [7:0]             bus_addr,
    input logic [31:0]            bus_rdata,
    input logic                   rescan,
    input logic [NUM_PINS*64-1:0] entries_flat
);

    AST_RESCAN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rescan |-> $past(bus_wr && (bus_addr == 8'h10))); // R11

    AST_RESCAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> !rescan); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd)); // R12

    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr != 8'h00) && (bus_addr != 8'h10)) |=> (bus_rdata == 32'h0)); // R3

    AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(entries_flat)); // R7

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_leg
        AST_ENTRY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            entries_flat[i*64 + 16] ||
            ((entries_flat[i*64 +: 8] >= 8'h10) && (entries_flat[i*64 +: 8] <= 8'hFE))); // R9
    end

endmodule

bind irq_route_regs irq_route_regs_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .rescan       (rescan),
    .entries_flat (entries_flat)
);

// File: tb/sim_irq_route_regs.sv
`timescale 1ns/1ps
module sim_irq_route_regs;

    localparam int         NP     = 24;
    localparam logic [7:0] ID_RST = 8'h00;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = 8'h00;
    logic [31:0]     bus_wdata = 32'h0;
    logic [31:0]     bus_rdata;
    logic            rescan;
    logic [NP*64-1:0] entries_flat;

    int n_checks = 0;
    int n_errors = 0;

    irq_route_regs #(.NUM_PINS(NP), .ID_RESET(ID_RST)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rescan(rescan), .entries_flat(entries_flat)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    logic [7:0]  m_sel;
    logic [7:0]  m_id;
    logic [63:0] m_ent [NP];
    logic        m_rescan;
    logic [31:0] m_rdata;

    function automatic logic [31:0] model_read(logic [7:0] a);
        int s, n;
        s = m_sel;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (s == 0) return {m_id, 24'h0};
        if (s == 1) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
        if (s < 16) return 32'h0;
        n = (s - 16) / 2;
        if (n >= NP) return 32'h0;
        return (s % 2 == 1) ? m_ent[n][63:32] : m_ent[n][31:0];
    endfunction

    always @(posedge clk) begin
        int s, n;
        if (!rst_n) begin
            m_sel    <= 8'h00;
            m_id     <= ID_RST;
            m_rescan <= 1'b0;
            m_rdata  <= 32'h0;
            for (int e = 0; e < NP; e++) m_ent[e] <= 64'h0000_0000_0001_0000;
        end else begin
            m_rescan <= 1'b0;
            if (bus_wr && bus_addr == 8'h00) begin
                m_sel <= bus_wdata[7:0];
            end else if (bus_wr && bus_addr == 8'h10) begin
                s = m_sel;
                if (s == 0) begin
                    m_id <= bus_wdata[31:24];
                end else if (s >= 16) begin
                    n = (s - 16) / 2;
                    if (n < NP) begin
                        m_rescan <= 1'b1;
                        if (s % 2 == 1)
                            m_ent[n][63:32] <= bus_wdata;
                        else if (bus_wdata[16] || (bus_wdata[7:0] >= 8'h10 && bus_wdata[7:0] <= 8'hFE))
                            m_ent[n][31:0] <= bus_wdata;
                    end
                end
            end
            if (bus_rd) m_rdata <= model_read(bus_addr);
        end
    end

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        check("R11 rescan", {63'h0, rescan}, {63'h0, m_rescan});
        check("R12 rdata", {32'h0, bus_rdata}, {32'h0, m_rdata});
        for (int e = 0; e < NP; e++)
            check("R7 entry", entries_flat[e*64 +: 64], m_ent[e]);
    end

    // Stimulus tasks: each starts and ends 1 ns after a rising edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [31:0] exp, string req);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
        check(req, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic win_wr_expect(logic [31:0] d, logic exp_rescan, string req);
        wr(8'h10, d);
        check(req, {63'h0, rescan}, {63'h0, exp_rescan});
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 rescan", {63'h0, rescan}, 64'h0);
        check("R1 rdata", {32'h0, bus_rdata}, 64'h0);
        check("R1 entry0", entries_flat[63:0], 64'h0000_0000_0001_0000);
        check("R1 entry23", entries_flat[23*64 +: 64], 64'h0000_0000_0001_0000);
        rd_expect(8'h00, 32'h0, "R1 sel");
        rd_expect(8'h10, {ID_RST, 24'h0}, "R1 id");

        // R2 select register
        wr(8'h00, 32'h0000_005A);
        rd_expect(8'h00, 32'h0000_005A, "R2 sel");
        wr(8'h00, 32'hFFFF_FF12);
        rd_expect(8'h00, 32'h0000_0012, "R2 sel upper ignored");

        // R4 identification
        wr(8'h00, 32'h0);
        win_wr_expect(32'hABCD_EF12, 1'b0, "R4 no rescan");
        rd_expect(8'h10, 32'hAB00_0000, "R4 id");

        // R5 version
        wr(8'h00, 32'h1);
        rd_expect(8'h10, 32'h0017_0011, "R5 version");
        win_wr_expect(32'hFFFF_FFFF, 1'b0, "R5 no rescan");
        rd_expect(8'h10, 32'h0017_0011, "R5 version after write");

        // R6 arbitration and gap selects
        wr(8'h00, 32'h2);
        rd_expect(8'h10, 32'h0, "R6 arb");
        win_wr_expect(32'h1234_5678, 1'b0, "R6 arb write");
        rd_expect(8'h10, 32'h0, "R6 arb after write");
        wr(8'h00, 32'h5);
        rd_expect(8'h10, 32'h0, "R6 gap select");

        // R3 undecoded offsets
        rd_expect(8'h04, 32'h0, "R3 offset 04");
        rd_expect(8'h14, 32'h0, "R3 offset 14");
        wr(8'h20, 32'h0000_0077);
        wr(8'h01, 32'h0000_0033);
        rd_expect(8'h00, 32'h0000_0005, "R3 sel untouched");

        // R7 entry mapping, R9 accepted vector
        wr(8'h00, 32'h10);
        win_wr_expect(32'h0000_0031, 1'b1, "R11 rescan on low write");
        check("R11 pulse ends", {63'h0, rescan}, 64'h1);
        idle(1);
        check("R11 one cycle", {63'h0, rescan}, 64'h0);
        check("R7 entry0 low", entries_flat[63:0], 64'h0000_0000_0000_0031);
        wr(8'h00, 32'h11);
        win_wr_expect(32'hFF00_0000, 1'b1, "R10 high write rescan");
        check("R10 entry0", entries_flat[63:0], 64'hFF00_0000_0000_0031);
        rd_expect(8'h10, 32'hFF00_0000, "R7 read high");
        wr(8'h00, 32'h10);
        rd_expect(8'h10, 32'h0000_0031, "R7 read low");

        // Last entry, both halves
        wr(8'h00, 32'h3F);
        win_wr_expect(32'h0000_0000, 1'b1, "R10 last high zero");
        wr(8'h00, 32'h3E);
        win_wr_expect(32'h0000_A0FE, 1'b1, "R9 vector FE");
        check("R7 entry23", entries_flat[23*64 +: 64], 64'h0000_0000_0000_A0FE);

        // R9 filter on entry 1
        wr(8'h00, 32'h12);
        win_wr_expect(32'h0000_0005, 1'b1, "R11 rescan on rejected write");
        check("R9 vec 05 dropped", entries_flat[64 +: 64], 64'h0000_0000_0001_0000);
        win_wr_expect(32'h0000_000F, 1'b1, "R11 rescan vec 0F");
        win_wr_expect(32'h0000_00FF, 1'b1, "R11 rescan vec FF");
        check("R9 vec FF dropped", entries_flat[64 +: 64], 64'h0000_0000_0001_0000);
        win_wr_expect(32'h0000_0010, 1'b1, "R11 rescan vec 10");
        check("R9 vec 10 kept", entries_flat[64 +: 64], 64'h0000_0000_0000_0010);
        win_wr_expect(32'h0001_0000, 1'b1, "R11 rescan masked");
        check("R9 masked vec 00 kept", entries_flat[64 +: 64], 64'h0000_0000_0001_0000);
        wr(8'h00, 32'h13);
        win_wr_expect(32'hDEAD_BEEF, 1'b1, "R10 high any value");
        check("R10 entry1", entries_flat[64 +: 64], 64'hDEAD_BEEF_0001_0000);

        // R8 beyond last entry
        wr(8'h00, 32'h40);
        rd_expect(8'h10, 32'h0, "R8 read beyond");
        win_wr_expect(32'h0000_0044, 1'b0, "R8 no rescan");
        wr(8'h00, 32'hFF);
        win_wr_expect(32'h1111_1111, 1'b0, "R8 sel FF no rescan");
        rd_expect(8'h10, 32'h0, "R8 read FF");

        // Read issued in the rescan cycle; back-to-back entry writes
        wr(8'h00, 32'h14);
        win_wr_expect(32'h0000_0042, 1'b1, "R11 write before read");
        rd_expect(8'h10, 32'h0000_0042, "R12 read in rescan cycle");
        check("R11 pulse after read", {63'h0, rescan}, 64'h0);
        win_wr_expect(32'h0000_0003, 1'b1, "R11 first of pair");
        win_wr_expect(32'h0000_0050, 1'b1, "R11 second of pair");
        rd_expect(8'h10, 32'h0000_0050, "R12 pair result");

        // R12 hold
        idle(4);
        check("R12 rdata held", {32'h0, bus_rdata}, 64'h0000_0000_0000_0050);
        rd_expect(8'h00, 32'h0000_0014, "R12 new read");
        idle(2);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule